// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block holds the program counter of a 32-bit RISC core whose instructions are all one word wide and word aligned, and chooses its successor every cycle. A decoder in front of it presents a three-bit control class together with the raw offset and index fields of the current instruction, the value of a source register for register-indirect jumps, and the two operands to compare for conditional branches. The block returns the address to fetch next and, for a call, the return address and its write strobe for register 31.

Conditional branches add a sign-extended word offset to the address of the following instruction. Absolute jumps keep the top bits of that address and splice in the index field. Register jumps take the register value as is, unless its two low bits are not zero. In that case the block raises a flag and keeps the counter where it is. The counter only moves on a clock edge where the step enable is high. Branch delay slots are not modelled.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_q` is loaded with the parameter `RESET_VEC` (default 0x0000_0100).
- R2: Class 0 (sequential) gives `next_pc = pc_q + 4`. The unused classes 6 and 7 behave the same way.
- R3: Class 1 (branch on equal) gives `pc_q + 4 + (sext(br_offset) << 2)` when `cmp_a == cmp_b`, and `pc_q + 4` otherwise.
- R4: Class 2 (branch on not equal) gives `pc_q + 4 + (sext(br_offset) << 2)` when `cmp_a != cmp_b`, and `pc_q + 4` otherwise.
- R5: The branch offset is a signed 16-bit word count. A negative offset moves the target below `pc_q + 4`.
- R6: Class 3 (jump) gives `{(pc_q+4)[31:28], jmp_index, 2'b00}`.
- R7: Class 4 (jump and link) gives the same target as R6, drives `link_we = 1` and `link_data = pc_q + 4` in the same cycle. `link_we` is 0 for every other class.
- R8: Class 5 (register jump) with `jr_value[1:0] == 0` gives `next_pc = jr_value` and `jr_misalign = 0`.
- R9: Class 5 with `jr_value[1:0] != 0` drives `jr_misalign = 1` and `next_pc = pc_q`, so the counter keeps its value. `jr_misalign` is 0 for every other class.
- R10: On a rising edge with `step_en` high, `pc_q` takes `next_pc`. With `step_en` low, `pc_q` keeps its value, while `next_pc` still shows the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_en | input | 1 | Advance the counter on this edge |
| ctl_class | input | 3 | Control class: 0 seq, 1 beq, 2 bne, 3 jump, 4 jump-link, 5 register jump |
| br_offset | input | 16 | Signed branch word offset |
| jmp_index | input | 26 | Absolute jump word index |
| jr_value | input | 32 | Register value for a register jump |
| cmp_a | input | 32 | First branch compare operand |
| cmp_b | input | 32 | Second branch compare operand |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Selected successor address |
| link_we | output | 1 | Write strobe for the return address into register 31 |
| link_data | output | 32 | Return address (current PC + 4) |
| jr_misalign | output | 1 | Register jump target not word aligned |

## Verification
Two functions can land in the same cycle. A jump and link redirects the counter and writes the return address at once. A misaligned register jump raises its flag and holds the counter at once. Random class codes are mixed with directed jump-and-link and misaligned register-jump cycles. The step enable is sometimes low during these cycles. The combinational outputs are judged before the edge, against a bench model of the successor and link value. After the edge, `pc_q` is compared with that model's choice, so a redirect that drops the link value, or a flag that fails to hold the counter, shows up as a mismatch.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        CTL_SEQ = 3'd0,
        CTL_BEQ = 3'd1,
        CTL_BNE = 3'd2,
        CTL_JMP = 3'd3,
        CTL_JAL = 3'd4,
        CTL_JR  = 3'd5
    } ctl_class_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;
endpackage

// File: rtl/npc_branch_target.sv
module npc_branch_target #(
    parameter int W     = 32,
    parameter int OFF_W = 16
) (
    input  logic [W-1:0]     pc,
    input  logic [OFF_W-1:0] offset,
    output logic [W-1:0]     pc_plus4,
    output logic [W-1:0]     target
);
    localparam int EXT_W = W - OFF_W - 2;

    logic [W-1:0] disp;

    always_comb begin
        pc_plus4 = pc + W'(4);
        disp     = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target   = pc_plus4 + disp;
    end
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target #(
    parameter int W     = 32,
    parameter int IDX_W = 26
) (
    input  logic [W-1:0]     pc_plus4,
    input  logic [IDX_W-1:0] index,
    output logic [W-1:0]     target
);
    localparam int HI_W = W - IDX_W - 2;

    generate
        if (HI_W > 0) begin : g_region
            assign target = {pc_plus4[W-1 -: HI_W], index, 2'b00};
        end else begin : g_flat
            assign target = {index, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_compare.sv
module npc_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         equal
);
    logic [W-1:0] diff;

    always_comb begin
        diff  = a ^ b;
        equal = (diff == '0);
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100,
    parameter int          OFF_W     = 16,
    parameter int          IDX_W     = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic [2:0]  ctl_class,
    input  logic [15:0] br_offset,
    input  logic [25:0] jmp_index,
    input  logic [31:0] jr_value,
    input  logic [31:0] cmp_a,
    input  logic [31:0] cmp_b,
    output logic [31:0] pc_q,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [31:0] link_data,
    output logic        jr_misalign
);
    localparam int W = ADDR_W;

    pc_state_t  state_d, state_q;
    ctl_class_e cls;

    logic [W-1:0] pc_plus4, br_target, jmp_target;
    logic         ops_equal;

    assign cls = ctl_class_e'(ctl_class);

    npc_branch_target #(.W(W), .OFF_W(OFF_W)) u_branch (
        .pc       (state_q.pc),
        .offset   (br_offset),
        .pc_plus4 (pc_plus4),
        .target   (br_target)
    );

    npc_jump_target #(.W(W), .IDX_W(IDX_W)) u_jump (
        .pc_plus4 (pc_plus4),
        .index    (jmp_index),
        .target   (jmp_target)
    );

    npc_compare #(.W(W)) u_cmp (
        .a     (cmp_a),
        .b     (cmp_b),
        .equal (ops_equal)
    );

    always_comb begin
        next_pc     = pc_plus4;
        link_we     = 1'b0;
        jr_misalign = 1'b0;
        unique case (cls)
            CTL_BEQ: if (ops_equal)  next_pc = br_target;
            CTL_BNE: if (!ops_equal) next_pc = br_target;
            CTL_JMP: next_pc = jmp_target;
            CTL_JAL: begin
                next_pc = jmp_target;
                link_we = 1'b1;
            end
            CTL_JR: begin
                if (jr_value[1:0] != 2'b00) begin
                    jr_misalign = 1'b1;
                    next_pc     = state_q.pc;
                end else begin
                    next_pc = jr_value;
                end
            end
            default: next_pc = pc_plus4;
        endcase
        link_data = pc_plus4;
        state_d   = state_q;
        if (step_en) state_d.pc = next_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q.pc <= RESET_VEC;
        else        state_q    <= state_d;
    end

    assign pc_q = state_q.pc;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> pc_q == $past(pc_q));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ctl_class == 3'd0) |=> pc_q == $past(pc_q) + 32'd4);

    assert_jr_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ctl_class == 3'd5 && jr_value[1:0] == 2'b00)
            |=> pc_q == $past(jr_value));

    assert_misalign_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && jr_misalign) |=> $stable(pc_q));

    assert_link_only_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (ctl_class == 3'd4 && !jr_misalign));

    assert_flag_only_jr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jr_misalign |-> ctl_class == 3'd5);
endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
    localparam logic [31:0] RV = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [2:0]  ctl_class = 3'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_index = '0;
    logic [31:0] jr_value = '0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [31:0] pc_q, next_pc, link_data;
    logic        link_we, jr_misalign;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc;

    always #10 clk = ~clk;

    pc_sequencer #(.RESET_VEC(RV)) u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .ctl_class(ctl_class),
        .br_offset(br_offset), .jmp_index(jmp_index), .jr_value(jr_value),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .pc_q(pc_q), .next_pc(next_pc),
        .link_we(link_we), .link_data(link_data), .jr_misalign(jr_misalign)
    );

    function automatic logic [31:0] exp_next(input logic [31:0] pc, input logic [2:0] c,
            input logic [15:0] off, input logic [25:0] idx, input logic [31:0] jr,
            input logic [31:0] a, input logic [31:0] b);
        logic [31:0] p4, bt;
        p4 = pc + 32'd4;
        bt = p4 + {{14{off[15]}}, off, 2'b00};
        case (c)
            3'd1: return (a == b) ? bt : p4;
            3'd2: return (a != b) ? bt : p4;
            3'd3, 3'd4: return {p4[31:28], idx, 2'b00};
            3'd5: return (jr[1:0] != 2'b00) ? pc : jr;
            default: return p4;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic en, input logic [2:0] c,
            input logic [15:0] off, input logic [25:0] idx, input logic [31:0] jr,
            input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e;
        @(negedge clk);
        step_en = en; ctl_class = c; br_offset = off; jmp_index = idx;
        jr_value = jr; cmp_a = a; cmp_b = b;
        #1;
        e = exp_next(model_pc, c, off, idx, jr, a, b);
        check({req, " next_pc"}, next_pc, e);
        check("R7 link_we", {31'd0, link_we}, {31'd0, c == 3'd4});
        check("R7 link_data", link_data, model_pc + 32'd4);
        check("R9 jr_misalign", {31'd0, jr_misalign}, {31'd0, (c == 3'd5) && (jr[1:0] != 2'b00)});
        @(posedge clk);
        #1;
        if (en) model_pc = e;
        check(en ? {req, " pc_q"} : "R10 hold pc_q", pc_q, model_pc);
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4242);
        #25;
        check("R1 reset pc_q", pc_q, RV);
        rst_n = 1'b1;
        model_pc = RV;
        // directed corners
        step("R2 seq", 1'b1, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0);
        step("R2 unused code 6", 1'b1, 3'd6, 16'h7, 26'h5, 32'h3, 32'h0, 32'h0);
        step("R2 unused code 7", 1'b1, 3'd7, 16'h7, 26'h5, 32'h3, 32'h0, 32'h0);
        step("R3 beq taken", 1'b1, 3'd1, 16'h0010, 26'h0, 32'h0, 32'h55, 32'h55);
        step("R3 beq not taken", 1'b1, 3'd1, 16'h0010, 26'h0, 32'h0, 32'h55, 32'h56);
        step("R4 bne taken", 1'b1, 3'd2, 16'h0003, 26'h0, 32'h0, 32'h1, 32'h2);
        step("R4 bne not taken", 1'b1, 3'd2, 16'h0003, 26'h0, 32'h0, 32'h9, 32'h9);
        step("R5 backward beq", 1'b1, 3'd1, 16'hFFF8, 26'h0, 32'h0, 32'h0, 32'h0);
        step("R8 jr aligned", 1'b1, 3'd5, 16'h0, 26'h0, 32'hF000_0000, 32'h0, 32'h0);
        step("R6 jump keeps top bits", 1'b1, 3'd3, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0);
        step("R7 jal", 1'b1, 3'd4, 16'h0, 26'h000_0040, 32'h0, 32'h0, 32'h0);
        step("R9 jr misaligned", 1'b1, 3'd5, 16'h0, 26'h0, 32'h0000_0202, 32'h0, 32'h0);
        step("R9 jr misaligned b01", 1'b1, 3'd5, 16'h0, 26'h0, 32'h0000_0301, 32'h0, 32'h0);
        step("R10 jal held", 1'b0, 3'd4, 16'h0, 26'h123, 32'h0, 32'h0, 32'h0);
        step("R10 beq held", 1'b0, 3'd1, 16'h0100, 26'h0, 32'h0, 32'h4, 32'h4);
        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  c;
            logic [31:0] a, b, jr;
            logic        en;
            c  = 3'($urandom_range(0, 7));
            a  = $urandom;
            b  = ($urandom_range(0, 1) == 0) ? a : $urandom;
            jr = $urandom;
            if ($urandom_range(0, 3) != 0) jr[1:0] = 2'b00;
            en = ($urandom_range(0, 4) != 0);
            step("R2-R10 random", en, c, 16'($urandom), 26'($urandom), jr, a, b);
        end
        // reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 re-reset pc_q", pc_q, RV);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule